// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block drives the serial clock line of an I2C master. A 16-bit configuration word chooses between a standard-speed profile and a fast profile, picks one of two high/low ratios for the fast profile, and holds a 12-bit count. All SCL phase durations are whole multiples of that count, measured in cycles of the block clock. The line is driven open-drain: the block only ever pulls SCL low or lets it go.

A bit-level controller above this block raises `run` while it needs a clock. It uses the two strobes to move SDA at the start of each low phase and to sample SDA when the high phase begins. The sensed line level `scl_in` feeds back into the high-phase counter, so a slave that stretches the clock delays the high phase but never shortens it. The same block keeps the master-mode flag. The controller sets this flag when it has issued a start, and the flag drops on a stop, on lost arbitration, or when the peripheral is disabled.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset the configuration word reads 0x0000 and SCL is released. The word layout is bit 15 = fast select, bit 14 = duty select, bits 11:0 = count. A write made while `enable` is low is returned unchanged by `cfg_rdata`.
- R2: Bits 13:12 of the configuration word always read as zero, whatever value was written to them.
- R3: A write made while `enable` is high is ignored. Both the readback and the SCL timing stay as they were.
- R4: In standard mode (bit 15 = 0), the low phase and the high phase each last count cycles.
- R5: In fast mode with duty select 0, the high phase lasts count cycles and the low phase lasts 2 × count cycles.
- R6: In fast mode with duty select 1, the high phase lasts 9 × count cycles and the low phase lasts 16 × count cycles.
- R7: A count below the legal minimum is used as that minimum. The minimum is 1 in fast mode with duty select 1, and 4 in every other mode.
- R8: While `enable` or `run` is low, SCL is released (`scl_drive_low` = 0) and the phase counter is cleared. When both are high again, the first phase is a full low phase.
- R9: `scl_fall_stb` is high for exactly one cycle, the first cycle of each low phase. `scl_rise_stb` is high for exactly one cycle, the first counted cycle of each high phase. The two are never high together.
- R10: The high phase counts only those cycles in which `scl_in` is sensed high. A slave holding SCL low for extra cycles lengthens the released time by that amount.
- R11: `master_mode` rises one cycle after a `start_evt` seen while enabled. It falls one cycle after `stop_evt`, `arb_lost` or a low `enable`, and a clear wins over a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all phase times count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; configuration writable only while low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| run | input | 1 | Clock request from the bit-level controller |
| scl_in | input | 1 | Sensed SCL line level |
| start_evt | input | 1 | Pulse: start condition issued, enter master operation |
| stop_evt | input | 1 | Pulse: stop detected on the bus |
| arb_lost | input | 1 | Pulse: arbitration lost |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| scl_fall_stb | output | 1 | One-cycle pulse at the start of each low phase |
| scl_rise_stb | output | 1 | One-cycle pulse at the first counted high cycle |
| master_mode | output | 1 | Master-mode status flag |

## Verification
The hardest case to reach from the ports is a high phase that is released but not yet counted, because the bench must hold the sensed line low after the block lets go. The bench models the line as the block's own drive combined with a slave hold signal. It raises the hold during a low phase and drops it a chosen number of samples into the high phase. The released time is then expected to grow by exactly that many cycles minus one. Random configurations, including counts below the legal minimum in every mode, are checked against phase lengths that bench functions compute.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int CFG_W    = 16;
  localparam int CNT_W    = 12;
  localparam int FAST_BIT = 15;
  localparam int DUTY_BIT = 14;
  localparam int MIN_STD  = 4;
  localparam int MIN_FD1  = 1;
  localparam int HI_MUL_FD1 = 9;
  localparam int LO_MUL_FD1 = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
  import scl_gen_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic               fast_sel,
  output logic               duty_sel,
  output logic [CNT_W_P-1:0] count
);
  localparam int PAD_W = CFG_W - 2 - CNT_W_P;

  logic               fast_q, fast_d;
  logic               duty_q, duty_d;
  logic [CNT_W_P-1:0] cnt_q, cnt_d;
  logic               wr_en;

  assign wr_en = cfg_wr && !enable;

  always_comb begin
    fast_d = fast_q;
    duty_d = duty_q;
    cnt_d  = cnt_q;
    if (wr_en) begin
      fast_d = cfg_wdata[FAST_BIT];
      duty_d = cfg_wdata[DUTY_BIT];
      cnt_d  = cfg_wdata[CNT_W_P-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      duty_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_en) begin
      fast_q <= fast_d;
      duty_q <= duty_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cfg_rdata = {fast_q, duty_q, {PAD_W{1'b0}}, cnt_q};
  assign fast_sel  = fast_q;
  assign duty_sel  = duty_q;
  assign count     = cnt_q;

  // R3: configuration frozen while the peripheral is enabled
  a_r3_frozen_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(cnt_q) && $stable(fast_q) && $stable(duty_q)));

  // R2: reserved bits of the readback stay zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[13:12] == 2'b00);
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len
  import scl_gen_pkg::*;
#(
  parameter int CNT_W_P = CNT_W,
  localparam int PH_W   = CNT_W_P + 4
) (
  input  logic               fast_sel,
  input  logic               duty_sel,
  input  logic [CNT_W_P-1:0] count,
  output logic [PH_W-1:0]    high_len,
  output logic [PH_W-1:0]    low_len
);
  logic [CNT_W_P-1:0] min_cnt;
  logic [CNT_W_P-1:0] eff_cnt;
  logic [PH_W-1:0]    eff_w;
  logic               ratio_9_16;

  assign ratio_9_16 = fast_sel && duty_sel;

  always_comb begin
    min_cnt = ratio_9_16 ? CNT_W_P'(MIN_FD1) : CNT_W_P'(MIN_STD);
    eff_cnt = (count < min_cnt) ? min_cnt : count;
    eff_w   = PH_W'(eff_cnt);
  end

  always_comb begin
    if (!fast_sel) begin
      high_len = eff_w;
      low_len  = eff_w;
    end else if (!duty_sel) begin
      high_len = eff_w;
      low_len  = eff_w << 1;
    end else begin
      high_len = (eff_w << 3) + eff_w;
      low_len  = eff_w << 4;
    end
  end

  // R7: no phase shorter than the clamped minimum
  always_comb begin
    a_r7_min_len: assert (high_len >= PH_W'(1) && low_len >= PH_W'(1));
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int PH_W = CNT_W + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            scl_in,
  input  logic [PH_W-1:0] high_len,
  input  logic [PH_W-1:0] low_len,
  output logic            scl_drive_low,
  output logic            scl_fall_stb,
  output logic            scl_rise_stb
);
  phase_e          state_q, state_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic            low_done, high_done;

  assign low_done  = (cnt_q == low_len - PH_W'(1));
  assign high_done = (cnt_q == high_len - PH_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!active) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          state_d = PH_LOW;
          cnt_d   = '0;
        end
        PH_LOW: begin
          if (low_done) begin
            state_d = PH_HIGH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + PH_W'(1);
          end
        end
        PH_HIGH: begin
          if (scl_in) begin
            if (high_done) begin
              state_d = PH_LOW;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + PH_W'(1);
            end
          end
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign scl_drive_low = (state_q == PH_LOW);
  assign scl_fall_stb  = (state_q == PH_LOW) && (cnt_q == '0);
  assign scl_rise_stb  = (state_q == PH_HIGH) && (cnt_q == '0) && scl_in;

  // R4: low counter never passes the programmed low length
  a_r4_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_LOW) |-> (cnt_q < low_len));

  // R8: dropping the request releases the line on the next cycle
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !scl_drive_low);

  // R10: a stretched line holds the high counter
  a_r10_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && state_q == PH_HIGH && !scl_in) |=> $stable(cnt_q));

  // R9: strobes are single-cycle and exclusive
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall_stb && scl_rise_stb));
  a_r9_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_stb |=> !scl_fall_stb);
endmodule

// File: rtl/scl_master_flag.sv
module scl_master_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic arb_lost,
  output logic master_mode
);
  logic flag_q, flag_d;
  logic clr;

  assign clr = stop_evt || arb_lost || !enable;

  always_comb begin
    flag_d = flag_q;
    if (clr)            flag_d = 1'b0;
    else if (start_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign master_mode = flag_q;

  // R11: any clear source drops the flag one cycle later
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt || arb_lost || !enable) |=> !master_mode);
  // R11: start while enabled and not cleared raises the flag
  a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_evt && !stop_evt && !arb_lost) |=> master_mode);
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W_P = CNT_W,
  localparam int PH_W   = CNT_W_P + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             run,
  input  logic             scl_in,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             arb_lost,
  output logic             scl_drive_low,
  output logic             scl_fall_stb,
  output logic             scl_rise_stb,
  output logic             master_mode
);
  logic               fast_sel, duty_sel;
  logic [CNT_W_P-1:0] count;
  logic [PH_W-1:0]    high_len, low_len;
  logic               active;

  assign active = enable && run;

  scl_cfg_reg #(.CNT_W_P(CNT_W_P)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .fast_sel  (fast_sel),
    .duty_sel  (duty_sel),
    .count     (count)
  );

  scl_phase_len #(.CNT_W_P(CNT_W_P)) u_len (
    .fast_sel (fast_sel),
    .duty_sel (duty_sel),
    .count    (count),
    .high_len (high_len),
    .low_len  (low_len)
  );

  scl_phase_ctrl #(.PH_W(PH_W)) u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active),
    .scl_in        (scl_in),
    .high_len      (high_len),
    .low_len       (low_len),
    .scl_drive_low (scl_drive_low),
    .scl_fall_stb  (scl_fall_stb),
    .scl_rise_stb  (scl_rise_stb)
  );

  scl_master_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .arb_lost    (arb_lost),
    .master_mode (master_mode)
  );
endmodule

// File: tb/i2c_scl_gen_tb.sv
module i2c_scl_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  logic        run = 1'b0;
  logic        hold = 1'b0;
  logic        scl_in;
  logic        start_evt = 1'b0, stop_evt = 1'b0, arb_lost = 1'b0;
  logic        scl_drive_low, scl_fall_stb, scl_rise_stb, master_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign scl_in = scl_drive_low ? 1'b0 : !hold;

  i2c_scl_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .run(run), .scl_in(scl_in),
    .start_evt(start_evt), .stop_evt(stop_evt), .arb_lost(arb_lost),
    .scl_drive_low(scl_drive_low), .scl_fall_stb(scl_fall_stb),
    .scl_rise_stb(scl_rise_stb), .master_mode(master_mode)
  );

  function automatic int eff_cnt(logic [15:0] c);
    int n = int'(c[11:0]);
    int mn = (c[15] && c[14]) ? 1 : 4;
    return (n < mn) ? mn : n;
  endfunction

  function automatic int exp_high(logic [15:0] c);
    int n = eff_cnt(c);
    if (!c[15]) return n;
    return c[14] ? 9 * n : n;
  endfunction

  function automatic int exp_low(logic [15:0] c);
    int n = eff_cnt(c);
    if (!c[15]) return n;
    return c[14] ? 16 * n : 2 * n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [15:0] v);
    @(negedge clk);
    cfg_wdata = v;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // measure one full period starting at a fall strobe; stretch > 0 holds the line
  task automatic measure(input int stretch, output int lo, output int hi,
                         output int rises, output bit fall_next);
    while (!scl_fall_stb) @(negedge clk);
    if (stretch > 0) hold = 1'b1;
    lo = 0;
    while (scl_drive_low) begin
      lo++;
      @(negedge clk);
    end
    hi = 0;
    rises = 0;
    while (!scl_drive_low) begin
      hi++;
      if (scl_rise_stb) rises++;
      if (hi >= stretch) hold = 1'b0;
      @(negedge clk);
    end
    fall_next = scl_fall_stb;
  endtask

  task automatic start_clock(logic [15:0] v);
    @(negedge clk);
    enable = 1'b0;
    run = 1'b0;
    write_cfg(v);
    enable = 1'b1;
    run = 1'b1;
  endtask

  task automatic check_period(logic [15:0] v, string req);
    int lo, hi, rs;
    bit fn;
    measure(0, lo, hi, rs, fn);
    check(lo == exp_low(v), req, lo, exp_low(v));
    check(hi == exp_high(v), req, hi, exp_high(v));
    check(rs == 1, "R9", rs, 1);
    check(fn, "R9", int'(fn), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int lo, hi, rs;
    bit fn;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cfg_rdata == 16'h0000, "R1", int'(cfg_rdata), 0);
    check(!scl_drive_low && !scl_fall_stb && !scl_rise_stb, "R1", int'(scl_drive_low), 0);
    check(!master_mode, "R11", int'(master_mode), 0);

    // R1/R2: readback with reserved bits forced to zero
    write_cfg(16'hFFFF);
    check(cfg_rdata == 16'hCFFF, "R2", int'(cfg_rdata), 'hCFFF);
    write_cfg(16'h8123);
    check(cfg_rdata == 16'h8123, "R1", int'(cfg_rdata), 'h8123);

    // R4: standard mode, 40-cycle phases
    start_clock(16'h0028);
    check_period(16'h0028, "R4");

    // R3: write while enabled is ignored, timing unchanged
    write_cfg(16'h8005);
    check(cfg_rdata == 16'h0028, "R3", int'(cfg_rdata), 'h28);
    check_period(16'h0028, "R3");

    // R5, R6: fast profiles
    start_clock(16'h800A);
    check_period(16'h800A, "R5");
    start_clock(16'hC003);
    check_period(16'hC003, "R6");

    // R7: clamping in each mode
    start_clock(16'h0001);
    check_period(16'h0001, "R7");
    start_clock(16'h8000);
    check_period(16'h8000, "R7");
    start_clock(16'hC000);
    check_period(16'hC000, "R7");

    // R10: slave stretches the high phase
    start_clock(16'h000A);
    measure(7, lo, hi, rs, fn);
    check(lo == 10, "R10", lo, 10);
    check(hi == 10 + 6, "R10", hi, 16);

    // R8: drop run in the middle of a low phase
    start_clock(16'h0014);
    while (!scl_fall_stb) @(negedge clk);
    repeat (5) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(!scl_drive_low, "R8", int'(scl_drive_low), 0);
    repeat (3) @(negedge clk);
    check(!scl_drive_low, "R8", int'(scl_drive_low), 0);
    run = 1'b1;
    @(negedge clk);
    check(scl_fall_stb && scl_drive_low, "R8", int'(scl_fall_stb), 1);
    lo = 0;
    while (scl_drive_low) begin lo++; @(negedge clk); end
    check(lo == 20, "R8", lo, 20);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_drive_low, "R8", int'(scl_drive_low), 0);

    // R11: master flag
    enable = 1'b1;
    run = 1'b0;
    start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
    check(master_mode, "R11", int'(master_mode), 1);
    stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
    check(!master_mode, "R11", int'(master_mode), 0);
    start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
    arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
    check(!master_mode, "R11", int'(master_mode), 0);
    start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
    enable = 1'b0; @(negedge clk);
    check(!master_mode, "R11", int'(master_mode), 0);
    start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
    check(!master_mode, "R11", int'(master_mode), 0);
    enable = 1'b1;
    start_evt = 1'b1; stop_evt = 1'b1; @(negedge clk);
    start_evt = 1'b0; stop_evt = 1'b0;
    check(!master_mode, "R11", int'(master_mode), 0);

    // random configurations across all profiles
    for (int i = 0; i < 24; i++) begin
      v = 16'($urandom);
      v[11:0] = (i % 4 == 0) ? 12'($urandom_range(0, 5)) : 12'($urandom_range(0, 50));
      start_clock(v);
      check(cfg_rdata == (v & 16'hCFFF), "R2", int'(cfg_rdata), int'(v & 16'hCFFF));
      check_period(v, v[15] ? (v[14] ? "R6" : "R5") : "R4");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule